// File: doc/BRIEF.md
# BCH Error-Locator Root Search

This block finds the error positions of one BCH-protected sector once the error-locator polynomial (sigma) is known. Software first stops any running search and then writes the sigma coefficients into indexed slots. It then writes a configuration word that holds the polynomial degree and selects the sector size, which also selects the Galois field (GF(2^13) for 512-byte sectors, GF(2^14) for 1024-byte sectors). A final write starts the search and gives the codeword length in bits. The engine then tests one candidate bit position per clock cycle. Position p is a root when sigma evaluated at alpha^(-p) is zero.

Found positions are numbered from 1 and kept in ascending order, up to the design capability T. When the search ends, software polls a status word for the done flag and the root count, and reads the positions back by index. A small corrector stage turns any selected stored position into a byte index and a bit index. It classifies the byte as data, parity or out of range. It flags the sector as uncorrectable when the number of roots differs from the configured degree.

Top module: `bch_chien_top`

## Requirements
- R1: After reset the status word reads 0: done (bit 0) is low, busy (bit 1) is low and the root count (bits 12:8) is zero.
- R2: A write to address 0x00 sets the degree from data bits 20:16 and the field from data bit 0. A 0 in bit 0 selects 512-byte sectors over GF(2^13) with x^13+x^4+x^3+x+1. A 1 selects 1024-byte sectors over GF(2^14) with x^14+x^10+x^6+x+1.
- R3: A write to address 0x20+j stores coefficient j of sigma (the coefficient of x^j), for j = 0..T. Slots above the configured degree do not take part in the search, even if they hold old values.
- R4: A write to address 0x01 while idle starts a search over positions 1 up to data bits 15:0 and clears the count. A length of 0 sets done on the next cycle with no roots.
- R5: Position p is counted exactly when sigma(alpha^(-p)) = 0. When the last position has been tested, done is set, busy is cleared and the count is final.
- R6: The first T roots are stored in ascending order and read back at address 0x40+i. The count keeps running past T and saturates at 31.
- R7: A write to address 0x02 aborts a search and clears done, busy and the count. While a search is running, writes to the other addresses are ignored.
- R8: For the stored position selected by fix_sel, fix_byte = (p-1)/8 and fix_bit = (p-1)%8. fix_valid is high when done is set and fix_sel is below the count.
- R9: fix_parity is high for a byte index from the sector size up to the sector size plus ceil(m*T/8). fix_range_err is high at or beyond that limit. Neither is high below the sector size.
- R10: sector_fail is high exactly when done is set and the count differs from the configured degree.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 32 | Read data (status or stored position) |
| fix_sel | input | IW | Index of the stored position to map |
| fix_valid | output | 1 | Selected position holds a found root |
| fix_byte | output | LW-3 | Byte index of the selected position |
| fix_bit | output | 3 | Bit index of the selected position |
| fix_parity | output | 1 | Byte lies in the parity area |
| fix_range_err | output | 1 | Byte lies beyond sector plus parity |
| sector_fail | output | 1 | Root count differs from degree |

## Verification
The hardest situations to reach are root counts larger than T and the saturation of the count. A sigma of degree T or less has at most T roots, so no real polynomial can produce them. The bench writes an all-zero polynomial, which makes every position a root. This fills the store with 1..T and drives the count to 31. Stale coefficients above the degree come about naturally because the vector table goes from a degree-4 polynomial to lower degrees without clearing slots. Roots at position 1, at the last position and beyond the search length exercise the window edges.

// File: rtl/bch_chien_pkg.sv
package bch_chien_pkg;
    localparam int FW    = 14;   // widest field element
    localparam int CNT_W = 5;    // root count width in the status word

    localparam logic [7:0] A_CFG  = 8'h00;
    localparam logic [7:0] A_GO   = 8'h01;
    localparam logic [7:0] A_STOP = 8'h02;
    localparam logic [7:0] A_STAT = 8'h03;
    localparam logic [7:0] A_SIG  = 8'h20;
    localparam logic [7:0] A_POS  = 8'h40;

    localparam logic [FW:0] POLY13 = 15'h201B;
    localparam logic [FW:0] POLY14 = 15'h4443;

    // multiply a field element by alpha^-1 in the selected field
    function automatic logic [FW-1:0] div_alpha(input logic [FW-1:0] x, input logic big);
        logic [FW:0] p;
        logic [FW:0] t;
        p = big ? POLY14 : POLY13;
        t = {1'b0, x} ^ (x[0] ? p : '0);
        return t[FW:1];
    endfunction
endpackage

// File: rtl/bch_chien_core.sv
module bch_chien_core
    import bch_chien_pkg::*;
#(
    parameter int T  = 4,
    parameter int LW = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [7:0]              wr_addr,
    input  logic [31:0]             wr_data,
    output logic                    busy_o,
    output logic                    done_o,
    output logic [CNT_W-1:0]        cnt_o,
    output logic [CNT_W-1:0]        deg_o,
    output logic                    big_o,
    output logic [T-1:0][LW-1:0]    pos_o
);
    typedef struct packed {
        logic [T:0][FW-1:0]   sig;
        logic [T:0][FW-1:0]   acc;
        logic [T-1:0][LW-1:0] pos;
        logic [LW-1:0]        len;
        logic [LW-1:0]        idx;
        logic [CNT_W-1:0]     deg;
        logic [CNT_W-1:0]     cnt;
        logic                 big;
        logic                 busy;
        logic                 done;
    } st_t;

    st_t st_q, st_d;

    logic [FW-1:0] tap_nxt [T+1];
    logic [FW-1:0] eval_sum;

    // one tap per coefficient: acc_j * alpha^-j each step
    for (genvar j = 0; j <= T; j++) begin : g_tap
        always_comb begin
            tap_nxt[j] = st_q.acc[j];
            for (int k = 0; k < j; k++) begin
                tap_nxt[j] = div_alpha(tap_nxt[j], st_q.big);
            end
        end
    end

    always_comb begin
        eval_sum = '0;
        for (int j = 0; j <= T; j++) eval_sum ^= tap_nxt[j];
    end

    always_comb begin
        logic [LW-1:0] nidx;
        logic [7:0]    soff;
        logic [FW-1:0] fmask;
        st_d  = st_q;
        nidx  = st_q.idx + LW'(1);
        soff  = wr_addr - A_SIG;
        fmask = st_q.big ? 14'h3FFF : 14'h1FFF;
        if (wr_en && wr_addr == A_STOP) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b0;
            st_d.cnt  = '0;
        end else if (st_q.busy) begin
            for (int j = 0; j <= T; j++) st_d.acc[j] = tap_nxt[j];
            st_d.idx = nidx;
            if (eval_sum == '0) begin
                for (int i = 0; i < T; i++) begin
                    if (st_q.cnt == CNT_W'(i)) st_d.pos[i] = nidx;
                end
                if (st_q.cnt != {CNT_W{1'b1}}) st_d.cnt = st_q.cnt + CNT_W'(1);
            end
            if (nidx == st_q.len) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end else if (wr_en) begin
            if (wr_addr == A_CFG) begin
                st_d.deg = wr_data[16 +: CNT_W];
                st_d.big = wr_data[0];
            end else if (wr_addr == A_GO) begin
                st_d.len  = wr_data[LW-1:0];
                st_d.idx  = '0;
                st_d.cnt  = '0;
                st_d.pos  = '0;
                st_d.done = (wr_data[LW-1:0] == '0);
                st_d.busy = (wr_data[LW-1:0] != '0);
                for (int j = 0; j <= T; j++) begin
                    st_d.acc[j] = (CNT_W'(j) <= st_q.deg) ? (st_q.sig[j] & fmask) : '0;
                end
            end else begin
                for (int j = 0; j <= T; j++) begin
                    if (soff == 8'(j)) st_d.sig[j] = wr_data[FW-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = st_q.busy;
    assign done_o = st_q.done;
    assign cnt_o  = st_q.cnt;
    assign deg_o  = st_q.deg;
    assign big_o  = st_q.big;
    assign pos_o  = st_q.pos;
endmodule

// File: rtl/bch_chien_fix.sv
module bch_chien_fix #(
    parameter int T  = 4,
    parameter int LW = 16
) (
    input  logic [LW-1:0] pos_i,
    input  logic          big_i,
    output logic [LW-4:0] byte_o,
    output logic [2:0]    bit_o,
    output logic          parity_o,
    output logic          range_err_o
);
    localparam int BW      = LW - 3;
    localparam int ECC13   = (13 * T + 7) / 8;
    localparam int ECC14   = (14 * T + 7) / 8;
    localparam logic [BW-1:0] SECT_S = BW'(512);
    localparam logic [BW-1:0] SECT_L = BW'(1024);
    localparam logic [BW-1:0] LIM_S  = BW'(512 + ECC13);
    localparam logic [BW-1:0] LIM_L  = BW'(1024 + ECC14);

    logic [LW-1:0] off;
    logic [BW-1:0] sect, lim;

    always_comb begin
        off         = pos_i - LW'(1);
        byte_o      = off[LW-1:3];
        bit_o       = off[2:0];
        sect        = big_i ? SECT_L : SECT_S;
        lim         = big_i ? LIM_L : LIM_S;
        parity_o    = (byte_o >= sect) && (byte_o < lim);
        range_err_o = (byte_o >= lim);
    end
endmodule

// File: rtl/bch_chien_top.sv
module bch_chien_top
    import bch_chien_pkg::*;
#(
    parameter int T  = 4,
    parameter int LW = 16,
    localparam int IW = (T > 1) ? $clog2(T) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    wr_addr,
    input  logic [31:0]   wr_data,
    input  logic [7:0]    rd_addr,
    output logic [31:0]   rd_data,
    input  logic [IW-1:0] fix_sel,
    output logic          fix_valid,
    output logic [LW-4:0] fix_byte,
    output logic [2:0]    fix_bit,
    output logic          fix_parity,
    output logic          fix_range_err,
    output logic          sector_fail
);
    logic                 busy_w, done_w, big_w;
    logic [CNT_W-1:0]     cnt_w, deg_w;
    logic [T-1:0][LW-1:0] pos_w;
    logic [LW-1:0]        sel_pos;

    bch_chien_core #(.T(T), .LW(LW)) core_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .busy_o  (busy_w),
        .done_o  (done_w),
        .cnt_o   (cnt_w),
        .deg_o   (deg_w),
        .big_o   (big_w),
        .pos_o   (pos_w)
    );

    always_comb begin
        sel_pos = '0;
        for (int i = 0; i < T; i++) begin
            if (fix_sel == IW'(i)) sel_pos = pos_w[i];
        end
    end

    bch_chien_fix #(.T(T), .LW(LW)) fix_i (
        .pos_i       (sel_pos),
        .big_i       (big_w),
        .byte_o      (fix_byte),
        .bit_o       (fix_bit),
        .parity_o    (fix_parity),
        .range_err_o (fix_range_err)
    );

    assign fix_valid   = done_w && (CNT_W'(fix_sel) < cnt_w);
    assign sector_fail = done_w && (cnt_w != deg_w);

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_STAT) begin
            rd_data[0]          = done_w;
            rd_data[1]          = busy_w;
            rd_data[8 +: CNT_W] = cnt_w;
        end
        for (int i = 0; i < T; i++) begin
            if (rd_addr == A_POS + 8'(i)) rd_data[LW-1:0] = pos_w[i];
        end
    end
endmodule

// File: rtl/bch_chien_chk.sv
module bch_chien_chk
    import bch_chien_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [7:0]       wr_addr,
    input logic             busy,
    input logic             done,
    input logic [CNT_W-1:0] cnt,
    input logic             sector_fail
);
    // R7: stop clears everything on the next cycle
    a_r7_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_STOP) |=> (!done && !busy && cnt == '0));

    // R4: start from idle begins a search (or finishes at once) with zero count
    a_r4_go_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_en && wr_addr == A_GO) |=> ((busy || done) && cnt == '0));

    // R6: count never falls during a search unless stopped
    a_r6_cnt_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(wr_en && wr_addr == A_STOP)) |=> (cnt >= $past(cnt)));

    // R5: done and busy never together
    a_r5_done_excl_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));

    // R5: idle without writes keeps the result
    a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !wr_en) |=> ($stable(cnt) && $stable(done)));

    // R10: failure is only flagged with a finished search
    a_r10_fail_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        sector_fail |-> done);
endmodule

bind bch_chien_top bch_chien_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .busy        (busy_w),
    .done        (done_w),
    .cnt         (cnt_w),
    .sector_fail (sector_fail)
);

// File: tb/bch_chien_top_tb_top.sv
module bch_chien_top_tb_top;
    localparam int T  = 4;
    localparam int LW = 16;
    localparam int IW = 2;

    typedef struct packed {
        logic              big;
        logic [4:0]        deg;
        logic [15:0]       len;
        logic [3:0][15:0]  roots;
        logic [4:0]        exp_cnt;
        logic              exp_fail;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 5'd1, 16'd4148, {16'd0, 16'd0, 16'd0, 16'd5},        5'd1, 1'b0},
        '{1'b0, 5'd2, 16'd4148, {16'd0, 16'd0, 16'd4148, 16'd1},     5'd2, 1'b0},
        '{1'b1, 5'd3, 16'd8248, {16'd0, 16'd8248, 16'd8200, 16'd100}, 5'd3, 1'b0},
        '{1'b0, 5'd4, 16'd4148, {16'd40, 16'd30, 16'd20, 16'd10},    5'd4, 1'b0},
        '{1'b0, 5'd2, 16'd2000, {16'd0, 16'd0, 16'd3000, 16'd50},    5'd1, 1'b1},
        '{1'b1, 5'd0, 16'd300,  {16'd0, 16'd0, 16'd0, 16'd0},        5'd0, 1'b0},
        '{1'b0, 5'd1, 16'd4600, {16'd0, 16'd0, 16'd0, 16'd4500},     5'd1, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [7:0]    rd_addr = 8'h03;
    logic [31:0]   rd_data;
    logic [IW-1:0] fix_sel = '0;
    logic          fix_valid, fix_parity, fix_range_err, sector_fail;
    logic [LW-4:0] fix_byte;
    logic [2:0]    fix_bit;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    bch_chien_top #(.T(T), .LW(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .fix_sel(fix_sel), .fix_valid(fix_valid),
        .fix_byte(fix_byte), .fix_bit(fix_bit), .fix_parity(fix_parity),
        .fix_range_err(fix_range_err), .sector_fail(sector_fail)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wait_done(input int limit);
        logic [31:0] s;
        for (int i = 0; i < limit; i++) begin
            rd(8'h03, s);
            if (s[0]) break;
            @(negedge clk);
        end
    endtask

    // field arithmetic from R2
    function automatic logic [13:0] gf_mul(input logic [13:0] a, input logic [13:0] b, input logic big);
        logic [14:0] x, poly;
        logic [13:0] r;
        int m;
        m = big ? 14 : 13;
        poly = big ? 15'h4443 : 15'h201B;
        x = {1'b0, a};
        r = '0;
        for (int i = 0; i < 14; i++) begin
            if (b[i]) r ^= x[13:0];
            x = x << 1;
            if (x[m]) x ^= poly;
        end
        return r;
    endfunction

    function automatic logic [13:0] gf_pow(input int p, input logic big);
        logic [13:0] r;
        r = 14'd1;
        for (int i = 0; i < p; i++) r = gf_mul(r, 14'd2, big);
        return r;
    endfunction

    initial begin
        logic [31:0] s;
        logic [13:0] sig [5];
        logic [13:0] c;
        int exp_pos [4];
        int ne, sect, lim, eb, tmp;
        vec_t v;

        #1;
        rd(8'h03, s);
        check(s == 32'd0, "R1 status during reset", int'(s), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(8'h03, s);
        check(s == 32'd0, "R1 status after reset", int'(s), 0);

        for (int vi = 0; vi < NV; vi++) begin
            v = VECS[vi];
            for (int j = 0; j < 5; j++) sig[j] = '0;
            sig[0] = 14'd1;
            for (int r = 0; r < 4; r++) begin
                if (v.roots[r] != 0) begin
                    c = gf_pow(int'(v.roots[r]), v.big);
                    for (int j = 4; j >= 1; j--) sig[j] = sig[j] ^ gf_mul(c, sig[j-1], v.big);
                end
            end
            ne = 0;
            for (int r = 0; r < 4; r++) begin
                if (v.roots[r] != 0 && v.roots[r] <= v.len) begin
                    exp_pos[ne] = int'(v.roots[r]);
                    ne++;
                end
            end
            for (int a = 0; a < ne; a++)
                for (int b = 0; b + 1 < ne - a; b++)
                    if (exp_pos[b] > exp_pos[b+1]) begin
                        tmp = exp_pos[b]; exp_pos[b] = exp_pos[b+1]; exp_pos[b+1] = tmp;
                    end
            check(ne == int'(v.exp_cnt), "R5 table consistency", ne, int'(v.exp_cnt));

            // R3: only slots 0..deg written, stale higher slots must be ignored
            wr(8'h02, 32'd0);
            for (int j = 0; j <= int'(v.deg); j++) wr(8'h20 + 8'(j), {18'd0, sig[j]});
            wr(8'h00, {11'd0, v.deg, 15'd0, v.big});
            wr(8'h01, {16'd0, v.len});
            wait_done(int'(v.len) + 20);
            rd(8'h03, s);
            check(s[0] == 1'b1 && s[1] == 1'b0, "R5 done after search", int'(s[1:0]), 1);
            check(s[12:8] == v.exp_cnt, "R5 root count", int'(s[12:8]), int'(v.exp_cnt));
            check(sector_fail == v.exp_fail, "R10 sector fail", int'(sector_fail), int'(v.exp_fail));
            sect = v.big ? 1024 : 512;
            eb = v.big ? (14 * T + 7) / 8 : (13 * T + 7) / 8;
            lim = sect + eb;
            for (int i = 0; i < ne; i++) begin
                rd(8'h40 + 8'(i), s);
                check(int'(s) == exp_pos[i], "R6 stored position", int'(s), exp_pos[i]);
                fix_sel = IW'(i);
                #1;
                check(fix_valid == 1'b1, "R8 fix valid", int'(fix_valid), 1);
                check(int'(fix_byte) == (exp_pos[i] - 1) / 8 && int'(fix_bit) == (exp_pos[i] - 1) % 8,
                      "R8 byte and bit", int'(fix_byte) * 8 + int'(fix_bit), exp_pos[i] - 1);
                check(fix_parity == ((exp_pos[i] - 1) / 8 >= sect && (exp_pos[i] - 1) / 8 < lim) &&
                      fix_range_err == ((exp_pos[i] - 1) / 8 >= lim),
                      "R9 area class", int'({fix_parity, fix_range_err}),
                      int'({((exp_pos[i]-1)/8 >= sect && (exp_pos[i]-1)/8 < lim), ((exp_pos[i]-1)/8 >= lim)}));
            end
            if (ne < T) begin
                fix_sel = IW'(ne);
                #1;
                check(fix_valid == 1'b0, "R8 fix valid beyond count", int'(fix_valid), 0);
            end
        end

        // R6: zero polynomial makes every position a root, count saturates at 31
        wr(8'h02, 32'd0);
        for (int j = 0; j <= 4; j++) wr(8'h20 + 8'(j), 32'd0);
        wr(8'h00, {11'd0, 5'd4, 15'd0, 1'b0});
        wr(8'h01, 32'd40);
        wait_done(60);
        rd(8'h03, s);
        check(s[12:8] == 5'd31, "R6 count saturation", int'(s[12:8]), 31);
        for (int i = 0; i < T; i++) begin
            rd(8'h40 + 8'(i), s);
            check(int'(s) == i + 1, "R6 first T kept", int'(s), i + 1);
        end
        check(sector_fail == 1'b1, "R10 fail on excess roots", int'(sector_fail), 1);

        // R4: zero length finishes at once
        wr(8'h01, 32'd0);
        rd(8'h03, s);
        check(s[0] == 1'b1 && s[12:8] == 5'd0, "R4 zero length", int'(s[12:0]), 1);

        // R2/R7: root at 30, writes during busy ignored, rerun gives same result
        sig[0] = 14'd1; sig[1] = gf_pow(30, 1'b0);
        wr(8'h20, {18'd0, sig[0]});
        wr(8'h21, {18'd0, sig[1]});
        wr(8'h00, {11'd0, 5'd1, 15'd0, 1'b0});
        wr(8'h01, 32'd100);
        wr(8'h21, 32'h1234);
        wr(8'h00, {11'd0, 5'd3, 15'd0, 1'b1});
        wait_done(150);
        rd(8'h40, s);
        check(int'(s) == 30, "R7 busy writes ignored first run", int'(s), 30);
        wr(8'h01, 32'd100);
        wait_done(150);
        rd(8'h40, s);
        check(int'(s) == 30, "R7 busy writes ignored rerun", int'(s), 30);
        rd(8'h03, s);
        check(s[12:8] == 5'd1 && sector_fail == 1'b0, "R7 config kept", int'(s[12:8]), 1);

        // R7: abort mid-search
        wr(8'h01, 32'd4000);
        repeat (50) @(negedge clk);
        rd(8'h03, s);
        check(s[1] == 1'b1 && s[12:8] == 5'd1, "R4 busy mid-search", int'(s[12:0]), 32'h102);
        wr(8'h02, 32'd0);
        rd(8'h03, s);
        check(s == 32'd0, "R7 abort clears status", int'(s), 0);
        repeat (20) @(negedge clk);
        rd(8'h03, s);
        check(s == 32'd0, "R7 stays idle after abort", int'(s), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1500000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule